// File: doc/BRIEF.md
# Linked-List Multi-Buffer DMA Channel

This block is one DMA channel. It moves a chain of buffers from a source to a destination over a single memory master port. Software programs a descriptor pointer and a starting destination address, sets the controller enable, and then enables the channel. The engine reads a five-word descriptor from memory. It copies the buffer's beats one at a time, each beat a read followed by a write. When the buffer's beat count is reached, the engine follows the descriptor's next-pointer to the following buffer.

Each descriptor supplies a new source address and new control words. The destination address word in the descriptor is read but dropped, so the destination keeps running on from where the previous buffer stopped. The result is that several scattered source buffers are gathered into one contiguous destination region.

Each endpoint can be a memory, which needs no handshake. It can also be a peripheral paced by either a hardware request/acknowledge pair or a software-set request bit. A transaction is either a single beat or a chunk of beats. When the final buffer ends, the channel disables itself and raises a sticky interrupt. That interrupt is cleared by reading the status register.

Top module: `llist_dma`

## Requirements
- R1: After reset the channel is idle. `irq`, `mem_req`, `buf_done` and both acknowledge outputs are low, and every register, including status (word 8), reads 0.
- R2: A descriptor fetch starts only when the channel enable (word 1, bit 0) is 1 and the controller enable (word 0, bit 0) is also 1. While the controller enable is 0, no memory request is issued.
- R3: A fetch reads five words with word size (`mem_size`=2) at pointer+0, +4, +8, +12 and +16. The words are, in order: source address, destination address, next pointer, control A, control B. The source address is word 2, the destination word 3 and the next pointer word 4.
- R4: The destination word of each fetched descriptor is discarded. The destination address (word 3) keeps running across buffers from the value software programmed.
- R5: The source width is control A bits [13:12] and the destination width is bits [15:14], coded 0 byte, 1 halfword, 2 word; the width is driven on `mem_size`. The source mode is control B bits [1:0] and the destination mode is bits [3:2], coded 0 increment, 1 decrement, 2 or 3 fixed. After every beat, each address moves by its width in bytes according to its mode.
- R6: Control A bits [11:0] give the buffer length in beats. After that many beats, `buf_done` pulses for one cycle and control A (word 5) reads back with bit 31 (DONE) set.
- R7: A non-zero next pointer starts a fetch at that address. A zero pointer ends the chain: the channel enable reads 0 and `irq` rises.
- R8: `irq` stays high until status (word 8) is read. That read returns bit 0 = interrupt and bit 1 = busy, and clears the interrupt.
- R9: With the hardware select bit set (control B bit 4 for the source, bit 5 for the destination), no data beat starts until that side's request input is high. The side's acknowledge then pulses for one cycle after each transaction.
- R10: With the select bit clear and the endpoint not a memory, the engine waits for the software request bit (word 7, bit 0 for the source, bit 1 for the destination; writing 1 sets it). The engine clears that bit when the transaction ends.
- R11: A memory endpoint (control B bit 7 for the source, bit 8 for the destination) needs no request and gets no acknowledge.
- R12: With control B bit 6 set, a transaction moves CHUNK_BEATS beats, or fewer if fewer beats remain in the buffer. With bit 6 clear, a transaction moves one beat. Either way there is one acknowledge per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe (clears interrupt on status read) |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, right-aligned, valid with ack |
| src_req | input | 1 | Source hardware request |
| src_ack | output | 1 | Source hardware acknowledge pulse |
| dst_req | input | 1 | Destination hardware request |
| dst_ack | output | 1 | Destination hardware acknowledge pulse |
| buf_done | output | 1 | One-cycle pulse at each buffer end |
| irq | output | 1 | Sticky end-of-chain interrupt |

## Verification
The bench builds the channel with CHUNK_BEATS set to 4 and the 12-bit length field left as it is. A six-beat chunked buffer therefore splits into one full chunk and a two-beat remainder, which exercises the early transaction end when a buffer runs out. The small chunk size also keeps every buffer inside a 1 KiB bench memory.

// File: rtl/llist_dma_pkg.sv
package llist_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CHECK = 3'd2,
        ST_WAIT  = 3'd3,
        ST_READ  = 3'd4,
        ST_WRITE = 3'd5,
        ST_ACK   = 3'd6,
        ST_DONE  = 3'd7
    } dma_state_e;

    localparam logic [3:0] REG_GEN    = 4'd0;
    localparam logic [3:0] REG_CHEN   = 4'd1;
    localparam logic [3:0] REG_SADDR  = 4'd2;
    localparam logic [3:0] REG_DADDR  = 4'd3;
    localparam logic [3:0] REG_DPTR   = 4'd4;
    localparam logic [3:0] REG_CTLA   = 4'd5;
    localparam logic [3:0] REG_CTLB   = 4'd6;
    localparam logic [3:0] REG_SWREQ  = 4'd7;
    localparam logic [3:0] REG_STATUS = 4'd8;

    localparam int DESC_WORDS = 5;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step (
    input  logic [31:0] addr,
    input  logic [1:0]  width,
    input  logic [1:0]  mode,
    output logic [31:0] next_addr
);
    logic [31:0] step;

    always_comb begin
        step = 32'd1 << width;
        case (mode)
            2'd0:    next_addr = addr + step;
            2'd1:    next_addr = addr - step;
            default: next_addr = addr;
        endcase
    end
endmodule

// File: rtl/dma_hs_gate.sv
module dma_hs_gate (
    input  logic is_mem,
    input  logic hw_sel,
    input  logic hw_req,
    input  logic sw_req,
    input  logic txn_end,
    output logic ready,
    output logic hw_ack,
    output logic sw_clr
);
    assign ready  = is_mem | (hw_sel ? hw_req : sw_req);
    assign hw_ack = txn_end & ~is_mem & hw_sel;
    assign sw_clr = txn_end & ~is_mem & ~hw_sel;
endmodule

// File: rtl/llist_dma.sv
module llist_dma
    import llist_dma_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int CHUNK_BEATS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic        cfg_rd_en,
    input  logic [3:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        src_req,
    output logic        src_ack,
    input  logic        dst_req,
    output logic        dst_ack,
    output logic        buf_done,
    output logic        irq
);
    localparam int TC_W = $clog2(CHUNK_BEATS + 1);
    localparam logic [TC_W-1:0] CHUNK_LAST = TC_W'(CHUNK_BEATS);

    typedef struct packed {
        dma_state_e       st;
        logic             gen_en;
        logic             ch_en;
        logic [31:0]      saddr;
        logic [31:0]      daddr;
        logic [31:0]      dptr;
        logic [31:0]      fbase;
        logic [31:0]      ctla;
        logic [31:0]      ctlb;
        logic [2:0]       fidx;
        logic [LEN_W-1:0] beats;
        logic [TC_W-1:0]  tcnt;
        logic [31:0]      data;
        logic             sw_src;
        logic             sw_dst;
        logic             irq;
    } chan_state_t;

    chan_state_t q, d;

    logic [31:0]      src_next, dst_next;
    logic             src_rdy, dst_rdy, src_clr, dst_clr, txn_end;
    logic [LEN_W-1:0] len, beats_inc;
    logic [TC_W-1:0]  tcnt_inc;

    assign len       = q.ctla[LEN_W-1:0];
    assign beats_inc = q.beats + 1'b1;
    assign tcnt_inc  = q.tcnt + 1'b1;
    assign txn_end   = (q.st == ST_ACK);

    dma_addr_step u_src_step (
        .addr(q.saddr), .width(q.ctla[13:12]), .mode(q.ctlb[1:0]), .next_addr(src_next)
    );
    dma_addr_step u_dst_step (
        .addr(q.daddr), .width(q.ctla[15:14]), .mode(q.ctlb[3:2]), .next_addr(dst_next)
    );

    dma_hs_gate u_src_gate (
        .is_mem(q.ctlb[7]), .hw_sel(q.ctlb[4]), .hw_req(src_req), .sw_req(q.sw_src),
        .txn_end(txn_end), .ready(src_rdy), .hw_ack(src_ack), .sw_clr(src_clr)
    );
    dma_hs_gate u_dst_gate (
        .is_mem(q.ctlb[8]), .hw_sel(q.ctlb[5]), .hw_req(dst_req), .sw_req(q.sw_dst),
        .txn_end(txn_end), .ready(dst_rdy), .hw_ack(dst_ack), .sw_clr(dst_clr)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd2;
        mem_wdata = q.data;
        buf_done  = 1'b0;

        if (cfg_wr_en) begin
            case (cfg_addr)
                REG_GEN:   d.gen_en = cfg_wdata[0];
                REG_SWREQ: begin
                    d.sw_src = q.sw_src | cfg_wdata[0];
                    d.sw_dst = q.sw_dst | cfg_wdata[1];
                end
                default: begin
                    if (q.st == ST_IDLE) begin
                        case (cfg_addr)
                            REG_CHEN:  d.ch_en = cfg_wdata[0];
                            REG_SADDR: d.saddr = cfg_wdata;
                            REG_DADDR: d.daddr = cfg_wdata;
                            REG_DPTR:  d.dptr  = cfg_wdata;
                            REG_CTLA:  d.ctla  = cfg_wdata;
                            REG_CTLB:  d.ctlb  = cfg_wdata;
                            default: ;
                        endcase
                    end
                end
            endcase
        end

        if (cfg_rd_en && cfg_addr == REG_STATUS) d.irq = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (q.ch_en && q.gen_en) begin
                    d.st    = ST_FETCH;
                    d.fbase = q.dptr;
                    d.fidx  = '0;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.fbase + {27'd0, q.fidx, 2'b00};
                if (mem_ack) begin
                    case (q.fidx)
                        3'd0:    d.saddr = mem_rdata;
                        3'd2:    d.dptr  = mem_rdata;
                        3'd3:    d.ctla  = mem_rdata;
                        3'd4:    d.ctlb  = mem_rdata;
                        default: ;
                    endcase
                    if (q.fidx == 3'(DESC_WORDS - 1)) begin
                        d.st    = ST_CHECK;
                        d.beats = '0;
                    end else begin
                        d.fidx = q.fidx + 3'd1;
                    end
                end
            end
            ST_CHECK: begin
                if (q.beats == len) begin
                    d.st = ST_DONE;
                end else begin
                    d.st   = ST_WAIT;
                    d.tcnt = '0;
                end
            end
            ST_WAIT: begin
                if (src_rdy && dst_rdy) d.st = ST_READ;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = q.saddr;
                mem_size = q.ctla[13:12];
                if (mem_ack) begin
                    d.data  = mem_rdata;
                    d.saddr = src_next;
                    d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.daddr;
                mem_size = q.ctla[15:14];
                if (mem_ack) begin
                    d.daddr = dst_next;
                    d.beats = beats_inc;
                    d.tcnt  = tcnt_inc;
                    if (beats_inc == len || !q.ctlb[6] || tcnt_inc == CHUNK_LAST)
                        d.st = ST_ACK;
                    else
                        d.st = ST_READ;
                end
            end
            ST_ACK: begin
                if (src_clr) d.sw_src = 1'b0;
                if (dst_clr) d.sw_dst = 1'b0;
                d.st = ST_CHECK;
            end
            ST_DONE: begin
                buf_done   = 1'b1;
                d.ctla[31] = 1'b1;
                if (q.dptr != 32'd0) begin
                    d.st    = ST_FETCH;
                    d.fbase = q.dptr;
                    d.fidx  = '0;
                end else begin
                    d.st    = ST_IDLE;
                    d.ch_en = 1'b0;
                    d.irq   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (cfg_addr)
            REG_GEN:    cfg_rdata = {31'd0, q.gen_en};
            REG_CHEN:   cfg_rdata = {31'd0, q.ch_en};
            REG_SADDR:  cfg_rdata = q.saddr;
            REG_DADDR:  cfg_rdata = q.daddr;
            REG_DPTR:   cfg_rdata = q.dptr;
            REG_CTLA:   cfg_rdata = q.ctla;
            REG_CTLB:   cfg_rdata = q.ctlb;
            REG_SWREQ:  cfg_rdata = {30'd0, q.sw_dst, q.sw_src};
            REG_STATUS: cfg_rdata = {30'd0, (q.st != ST_IDLE), q.irq};
            default:    cfg_rdata = '0;
        endcase
    end

    assign irq = q.irq;

endmodule

// File: rtl/llist_dma_chk.sv
module llist_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd_en,
    input logic [3:0]  cfg_addr,
    input logic        irq,
    input logic        buf_done,
    input logic        src_ack,
    input logic        dst_ack,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr
);
    logic status_rd;
    assign status_rd = cfg_rd_en && (cfg_addr == 4'd8);

    p_irq_from_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(buf_done));

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !status_rd |=> irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && status_rd && !buf_done |=> !irq);

    p_bufdone_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !buf_done);

    p_src_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_ack |=> !src_ack);

    p_dst_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dst_ack |=> !dst_ack);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

endmodule

bind llist_dma llist_dma_chk u_chk (.*);

// File: tb/llist_dma_test.sv
module llist_dma_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        src_req = 1'b0, dst_req = 1'b0;
    logic        src_ack, dst_ack, buf_done, irq;

    logic        tb_we = 1'b0;
    logic [31:0] tb_wa = '0, tb_wd = '0;

    logic [7:0]  mem [0:1023];
    logic [31:0] rd_log [0:63];
    int rd_cnt = 0, wr_cnt = 0, sack_cnt = 0, dack_cnt = 0, bd_cnt = 0;
    int n_checks = 0, n_fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    llist_dma #(.LEN_W(12), .CHUNK_BEATS(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .src_req(src_req), .src_ack(src_ack), .dst_req(dst_req), .dst_ack(dst_ack),
        .buf_done(buf_done), .irq(irq)
    );

    assign mem_ack = mem_req;

    always_comb begin
        case (mem_size)
            2'd0:    mem_rdata = {24'd0, mem[mem_addr[9:0]]};
            2'd1:    mem_rdata = {16'd0, mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
            default: mem_rdata = {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                                  mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
        endcase
    end

    always @(posedge clk) begin
        if (tb_we) begin
            for (int k = 0; k < 4; k++) mem[tb_wa[9:0] + 10'(k)] = tb_wd[8*k +: 8];
        end else if (mem_req && mem_ack && mem_we) begin
            for (int k = 0; k < 4; k++)
                if (k < (1 << mem_size)) mem[mem_addr[9:0] + 10'(k)] = mem_wdata[8*k +: 8];
            wr_cnt++;
        end
        if (mem_req && mem_ack && !mem_we) begin
            rd_log[rd_cnt % 64] = mem_addr;
            rd_cnt++;
        end
        if (src_ack)  sack_cnt++;
        if (dst_ack)  dack_cnt++;
        if (buf_done) bd_cnt++;
    end

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] wexp(input logic [31:0] a);
        return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {mem[a[9:0] + 10'd3], mem[a[9:0] + 10'd2], mem[a[9:0] + 10'd1], mem[a[9:0]]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] v);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] v);
        cfg_rd_en = 1'b1; cfg_addr = a;
        #1 v = cfg_rdata;
        @(negedge clk);
        cfg_rd_en = 1'b0;
    endtask

    task automatic bwrite(input logic [31:0] a, input logic [31:0] v);
        tb_we = 1'b1; tb_wa = a; tb_wd = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] s, input logic [31:0] dd,
                            input logic [31:0] nx, input logic [31:0] ca, input logic [31:0] cb);
        bwrite(base, s);
        bwrite(base + 4, dd);
        bwrite(base + 8, nx);
        bwrite(base + 12, ca);
        bwrite(base + 16, cb);
    endtask

    task automatic start_chain(input logic [31:0] ptr, input logic [31:0] daddr);
        cfg_write(4'd4, ptr);
        cfg_write(4'd3, daddr);
        cfg_write(4'd1, 32'd1);
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {31'd0, irq}, 32'd1);
    endtask

    task automatic clear_irq();
        logic [31:0] v;
        cfg_read(4'd8, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 acks", {30'd0, src_ack, dst_ack}, 32'd0);
        cfg_read(4'd8, v); chk("R1 status", v, 32'd0);
        cfg_read(4'd1, v); chk("R1 chen", v, 32'd0);
        cfg_read(4'd2, v); chk("R1 saddr", v, 32'd0);
        cfg_read(4'd5, v); chk("R1 ctla", v, 32'd0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        int r0 = rd_cnt;
        put_desc(32'h100, 0, 0, 0, 32'h0000_A001, 32'h180);
        cfg_write(4'd4, 32'h100);
        cfg_write(4'd1, 32'd1);
        repeat (20) @(negedge clk);
        chk("R2 no fetch while controller off", rd_cnt - r0, 0);
        cfg_read(4'd8, v); chk("R2 not busy", v, 32'd0);
        cfg_write(4'd1, 32'd0);
        cfg_write(4'd0, 32'd1);
        repeat (10) @(negedge clk);
        chk("R2 no fetch with channel off", rd_cnt - r0, 0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        int r0, b0;
        put_desc(32'h100, 32'h000, 32'hDEAD_0000, 32'h120, 32'h0000_A003, 32'h180);
        put_desc(32'h120, 32'h040, 32'hBEEF_0000, 32'h000, 32'h0000_A002, 32'h180);
        r0 = rd_cnt; b0 = bd_cnt;
        start_chain(32'h100, 32'h200);
        wait_irq("R7 irq at chain end");
        for (int i = 0; i < 5; i++)
            chk("R3 fetch address order", rd_log[(r0 + i) % 64], 32'h100 + 32'(4 * i));
        chk("R3 first data read after fetch", rd_log[(r0 + 5) % 64], 32'h000);
        chk("R6 buffer pulses", bd_cnt - b0, 2);
        for (int i = 0; i < 3; i++)
            chk("R4 first buffer data", word_at(32'h200 + 32'(4 * i)), wexp(32'(4 * i)));
        for (int i = 0; i < 2; i++)
            chk("R4 second buffer contiguous", word_at(32'h20C + 32'(4 * i)), wexp(32'h40 + 32'(4 * i)));
        cfg_read(4'd3, v); chk("R4 daddr runs on", v, 32'h214);
        cfg_read(4'd2, v); chk("R5 saddr word increment", v, 32'h048);
        cfg_read(4'd5, v); chk("R6 done flag", v, 32'h8000_A002);
        cfg_read(4'd1, v); chk("R7 channel disabled", v, 32'd0);
        cfg_read(4'd8, v); chk("R8 status read", v, 32'd1);
        chk("R8 irq cleared", {31'd0, irq}, 32'd0);
        cfg_read(4'd8, v); chk("R8 second status read", v, 32'd0);
    endtask

    task automatic t_widths();
        logic [31:0] v;
        put_desc(32'h140, 32'h00A, 32'h0, 32'h0, 32'h0000_0004, 32'h181);
        start_chain(32'h140, 32'h300);
        wait_irq("R5 byte run end");
        for (int i = 0; i < 4; i++)
            chk("R5 byte decrement data", {24'd0, mem[10'h300 + 10'(i)]}, {24'd0, pat(32'h00A - 32'(i))});
        cfg_read(4'd3, v); chk("R5 daddr byte step", v, 32'h304);
        cfg_read(4'd2, v); chk("R5 saddr byte decrement", v, 32'h006);
        clear_irq();
        put_desc(32'h160, 32'h020, 32'h0, 32'h0, 32'h0000_5003, 32'h188);
        start_chain(32'h160, 32'h320);
        wait_irq("R5 half run end");
        chk("R5 fixed dst holds last halfword", {16'd0, mem[10'h321], mem[10'h320]},
            {16'd0, pat(32'h025), pat(32'h024)});
        cfg_read(4'd3, v); chk("R5 daddr fixed", v, 32'h320);
        cfg_read(4'd2, v); chk("R5 saddr half increment", v, 32'h026);
        clear_irq();
    endtask

    task automatic t_hw_chunk();
        int w0 = wr_cnt, s0 = sack_cnt, d0 = dack_cnt;
        put_desc(32'h180, 32'h080, 32'h0, 32'h0, 32'h0000_A006, 32'h150);
        start_chain(32'h180, 32'h380);
        repeat (20) @(negedge clk);
        chk("R9 no beat without request", wr_cnt - w0, 0);
        src_req = 1'b1;
        wait_irq("R12 chunk run end");
        src_req = 1'b0;
        chk("R12 acks per chunk", sack_cnt - s0, 2);
        chk("R11 memory side no ack", dack_cnt - d0, 0);
        chk("R12 beats moved", wr_cnt - w0, 6);
        chk("R12 remainder data", word_at(32'h394), wexp(32'h094));
        clear_irq();
        w0 = wr_cnt; d0 = dack_cnt; s0 = sack_cnt;
        put_desc(32'h1C0, 32'h0E0, 32'h0, 32'h0, 32'h0000_A002, 32'h0A0);
        dst_req = 1'b1;
        start_chain(32'h1C0, 32'h3C0);
        wait_irq("R9 dst hw run end");
        dst_req = 1'b0;
        chk("R12 single beat acks", dack_cnt - d0, 2);
        chk("R11 memory src no ack", sack_cnt - s0, 0);
        chk("R9 dst data", word_at(32'h3C4), wexp(32'h0E4));
        clear_irq();
    endtask

    task automatic t_sw();
        logic [31:0] v;
        int w0 = wr_cnt;
        put_desc(32'h1A0, 32'h0C0, 32'h0, 32'h0, 32'h0000_A002, 32'h100);
        start_chain(32'h1A0, 32'h3A0);
        repeat (15) @(negedge clk);
        chk("R10 waits for soft request", wr_cnt - w0, 0);
        cfg_write(4'd7, 32'd1);
        repeat (15) @(negedge clk);
        chk("R10 one beat per soft request", wr_cnt - w0, 1);
        cfg_read(4'd7, v); chk("R10 soft bit cleared", v, 32'd0);
        cfg_write(4'd7, 32'd1);
        wait_irq("R10 run end");
        chk("R10 data", word_at(32'h3A4), wexp(32'h0C4));
        clear_irq();
    endtask

    task automatic run_all();
        for (int i = 0; i < 64; i++) bwrite(32'(4 * i), wexp(32'(4 * i)));
        t_gate();
        t_chain();
        t_widths();
        t_hw_chunk();
        t_sw();
    endtask

    initial begin
        bit timeout = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                run_all();
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) chk("watchdog", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule